// File: doc/BRIEF.md
# Display Supply Power Sequencer

This block is the digital controller of a multi-rail display power supply. It orders the turn-on and turn-off of a logic-supply switch, a switching converter core, a post-regulated main rail and a pair of gate-drive rails, one negative and one positive. The analog side is not modelled. The comparators and regulators report to the block only through single-bit flags, and the block answers with plain enable levels. All flags and the two control inputs are asynchronous, and each passes through a two-flop synchroniser before the state machine sees it.

Power-up goes through the logic switch, then the converter, then the main rail while the enable input is high. The negative gate rail follows once the main rail reports 90 % of nominal. The positive gate rail follows once the negative rail reports 90 %. On power-down both gate rails drop together and the positive rail is actively discharged. The main rail is held until the negative feedback reports its discharge crossing, and the logic supply goes off last. A rail that stays under its fault level for a programmable number of cycles while fully powered latches the block into shutdown. The block leaves shutdown only when both control inputs are low or when input undervoltage is reported.

Top module: `disp_pwr_seq`

## Requirements
- R1: While reset is asserted and straight after it, the outputs hold the rest state: `logic_sw_n` = 1, and `aux_en`, `core_en`, `main_en`, `neg_en`, `pos_en`, `pos_dis` and `fault` are all 0.
- R2: With `vin_ok` high, a high on `run` first drives `logic_sw_n` low and sets `aux_en`. `core_en` rises exactly one cycle later.
- R3: `main_en` rises only after `core_en` has been high for at least one cycle and only while `en` is high. If `en` falls before any gate rail is on, `main_en` clears and `core_en` stays set.
- R4: `neg_en` rises only while `main_en` is high and after `main_good` is seen. `pos_en` rises only after `neg_good` is seen while `neg_en` is high.
- R5: When `run` falls with the gate rails on, `neg_en` and `pos_en` clear in the same cycle and `pos_dis` sets. `main_en` stays on until `neg_fb_dis` is seen, then clears. One cycle later `logic_sw_n` returns to 1 and `aux_en` to 0.
- R6: With every rail on, if any of `main_flt`, `neg_flt` or `pos_flt` is seen on FAULT_CYCLES consecutive cycles, `fault` sets and `main_en`, `neg_en`, `pos_en` and `core_en` all clear together. A flag that drops earlier restarts the count.
- R7: In latched shutdown, `logic_sw_n` stays 0 and `aux_en` stays 1 until `main_low` is seen. After that, `logic_sw_n` = 1 and `aux_en` = 0, with `fault` still 1.
- R8: Latched shutdown ends, with `fault` cleared and the rest state restored, only when `run` and `en` are both low or when `vin_ok` is low. Either input low on its own has no effect.
- R9: When `vin_ok` goes low in any state, the block goes to the rest state of R1.
- R10: When `run` is low and `gate_hold` is high, the block drops every rail straight to the rest state without the ordered power-down and without `pos_dis`.
- R11: Each input passes through a two-flop synchroniser. A change driven between edges shows on the outputs after the third rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Master run request |
| en | input | 1 | Main-rail enable request |
| vin_ok | input | 1 | Input supply above undervoltage level |
| main_good | input | 1 | Main rail at or above 90 % of nominal |
| neg_good | input | 1 | Negative rail at or above 90 % of nominal |
| main_flt | input | 1 | Main rail under its fault level |
| neg_flt | input | 1 | Negative rail under its fault level |
| pos_flt | input | 1 | Positive rail under its fault level |
| neg_fb_dis | input | 1 | Negative feedback past its discharge level |
| main_low | input | 1 | Main rail below its shutdown level |
| gate_hold | input | 1 | Switch-control pin forced high externally |
| logic_sw_n | output | 1 | Logic-supply switch control, active low |
| aux_en | output | 1 | Auxiliary regulator enable |
| core_en | output | 1 | Converter core enable |
| main_en | output | 1 | Main rail enable |
| neg_en | output | 1 | Negative gate rail enable |
| pos_en | output | 1 | Positive gate rail enable |
| pos_dis | output | 1 | Positive rail active discharge |
| fault | output | 1 | Latched fault shutdown |

## Verification
The bench targets the fault timer at its boundary. Flag bursts shorter than the limit, separated by clear gaps, must never trip it. A counter that does not restart would latch early, and one off by a cycle would shift the fault edge against the reference. The bench also releases latched shutdown with each control input on its own and then with both. A design that clears on one input alone would drop `fault` too soon. Other cases are the ordered power-down, the bypass through `gate_hold`, and undervoltage during a fault. A design that skipped the discharge wait, or let the logic switch go before the main rail, would differ from the reference on the exact cycle.

// File: rtl/dps_pkg.sv
package dps_pkg;

  localparam int IX_RUN       = 0;
  localparam int IX_EN        = 1;
  localparam int IX_VIN_OK    = 2;
  localparam int IX_MAIN_GOOD = 3;
  localparam int IX_NEG_GOOD  = 4;
  localparam int IX_MAIN_FLT  = 5;
  localparam int IX_NEG_FLT   = 6;
  localparam int IX_POS_FLT   = 7;
  localparam int IX_NEG_FBDIS = 8;
  localparam int IX_MAIN_LOW  = 9;
  localparam int IX_GATE_HOLD = 10;
  localparam int NUM_IN       = 11;

  typedef enum logic [3:0] {
    ST_IDLE        = 4'd0,
    ST_LOGIC_ON    = 4'd1,
    ST_CORE_ON     = 4'd2,
    ST_MAIN_ON     = 4'd3,
    ST_NEG_ON      = 4'd4,
    ST_POS_ON      = 4'd5,
    ST_PD_GATES    = 4'd6,
    ST_PD_MAIN     = 4'd7,
    ST_FAULT_LATCH = 4'd8,
    ST_FAULT_HOLD  = 4'd9
  } seq_state_t;

  typedef struct packed {
    logic logic_sw_n;
    logic aux_en;
    logic core_en;
    logic main_en;
    logic neg_en;
    logic pos_en;
    logic pos_dis;
    logic fault;
  } rail_ctrl_t;

  function automatic rail_ctrl_t decode_state(seq_state_t s);
    rail_ctrl_t c;
    c = '{logic_sw_n: 1'b1, default: 1'b0};
    case (s)
      ST_LOGIC_ON: begin
        c.logic_sw_n = 1'b0; c.aux_en = 1'b1;
      end
      ST_CORE_ON: begin
        c.logic_sw_n = 1'b0; c.aux_en = 1'b1; c.core_en = 1'b1;
      end
      ST_MAIN_ON: begin
        c.logic_sw_n = 1'b0; c.aux_en = 1'b1; c.core_en = 1'b1;
        c.main_en = 1'b1;
      end
      ST_NEG_ON: begin
        c.logic_sw_n = 1'b0; c.aux_en = 1'b1; c.core_en = 1'b1;
        c.main_en = 1'b1; c.neg_en = 1'b1;
      end
      ST_POS_ON: begin
        c.logic_sw_n = 1'b0; c.aux_en = 1'b1; c.core_en = 1'b1;
        c.main_en = 1'b1; c.neg_en = 1'b1; c.pos_en = 1'b1;
      end
      ST_PD_GATES: begin
        c.logic_sw_n = 1'b0; c.aux_en = 1'b1; c.core_en = 1'b1;
        c.main_en = 1'b1; c.pos_dis = 1'b1;
      end
      ST_PD_MAIN: begin
        c.logic_sw_n = 1'b0; c.aux_en = 1'b1; c.core_en = 1'b1;
        c.pos_dis = 1'b1;
      end
      ST_FAULT_LATCH: begin
        c.logic_sw_n = 1'b0; c.aux_en = 1'b1; c.fault = 1'b1;
      end
      ST_FAULT_HOLD: begin
        c.fault = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/dps_fault_timer.sv
module dps_fault_timer #(
  parameter int CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic flag,
  output logic expired
);

  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = (cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!(arm && flag)) begin
      cnt <= '0;
    end else if (!hit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = arm && flag && hit;

endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
  import dps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       en,
  input  logic       vin_ok,
  input  logic       main_good,
  input  logic       neg_good,
  input  logic       neg_fb_dis,
  input  logic       main_low,
  input  logic       gate_hold,
  input  logic       flt_expired,
  output seq_state_t state
);

  seq_state_t nxt;
  logic       bypass_off;
  logic       shut_req;
  logic       both_low;

  assign bypass_off = !run && gate_hold;
  assign shut_req   = !run || !en;
  assign both_low   = !run && !en;

  always_comb begin
    nxt = state;
    if (!vin_ok) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:     if (run) nxt = ST_LOGIC_ON;
        ST_LOGIC_ON: nxt = run ? ST_CORE_ON : ST_IDLE;
        ST_CORE_ON: begin
          if (!run)    nxt = ST_IDLE;
          else if (en) nxt = ST_MAIN_ON;
        end
        ST_MAIN_ON: begin
          if (!run)           nxt = ST_IDLE;
          else if (!en)       nxt = ST_CORE_ON;
          else if (main_good) nxt = ST_NEG_ON;
        end
        ST_NEG_ON: begin
          if (bypass_off)    nxt = ST_IDLE;
          else if (shut_req) nxt = ST_PD_GATES;
          else if (neg_good) nxt = ST_POS_ON;
        end
        ST_POS_ON: begin
          if (flt_expired)     nxt = ST_FAULT_LATCH;
          else if (bypass_off) nxt = ST_IDLE;
          else if (shut_req)   nxt = ST_PD_GATES;
        end
        ST_PD_GATES: begin
          if (bypass_off)      nxt = ST_IDLE;
          else if (neg_fb_dis) nxt = ST_PD_MAIN;
        end
        ST_PD_MAIN:  nxt = run ? ST_CORE_ON : ST_IDLE;
        ST_FAULT_LATCH: begin
          if (both_low)      nxt = ST_IDLE;
          else if (main_low) nxt = ST_FAULT_HOLD;
        end
        ST_FAULT_HOLD: if (both_low) nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import dps_pkg::*;
#(
  parameter int FAULT_CYCLES = 10000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  input  logic vin_ok,
  input  logic main_good,
  input  logic neg_good,
  input  logic main_flt,
  input  logic neg_flt,
  input  logic pos_flt,
  input  logic neg_fb_dis,
  input  logic main_low,
  input  logic gate_hold,
  output logic logic_sw_n,
  output logic aux_en,
  output logic core_en,
  output logic main_en,
  output logic neg_en,
  output logic pos_en,
  output logic pos_dis,
  output logic fault
);

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] syn;
  logic              any_flt;
  logic              expired;
  seq_state_t        state;
  rail_ctrl_t        ctl;

  assign raw_in[IX_RUN]       = run;
  assign raw_in[IX_EN]        = en;
  assign raw_in[IX_VIN_OK]    = vin_ok;
  assign raw_in[IX_MAIN_GOOD] = main_good;
  assign raw_in[IX_NEG_GOOD]  = neg_good;
  assign raw_in[IX_MAIN_FLT]  = main_flt;
  assign raw_in[IX_NEG_FLT]   = neg_flt;
  assign raw_in[IX_POS_FLT]   = pos_flt;
  assign raw_in[IX_NEG_FBDIS] = neg_fb_dis;
  assign raw_in[IX_MAIN_LOW]  = main_low;
  assign raw_in[IX_GATE_HOLD] = gate_hold;

  dps_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn)
  );

  assign any_flt = syn[IX_MAIN_FLT] | syn[IX_NEG_FLT] | syn[IX_POS_FLT];

  dps_fault_timer #(.CYCLES(FAULT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (state == ST_POS_ON),
    .flag    (any_flt),
    .expired (expired)
  );

  dps_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (syn[IX_RUN]),
    .en          (syn[IX_EN]),
    .vin_ok      (syn[IX_VIN_OK]),
    .main_good   (syn[IX_MAIN_GOOD]),
    .neg_good    (syn[IX_NEG_GOOD]),
    .neg_fb_dis  (syn[IX_NEG_FBDIS]),
    .main_low    (syn[IX_MAIN_LOW]),
    .gate_hold   (syn[IX_GATE_HOLD]),
    .flt_expired (expired),
    .state       (state)
  );

  assign ctl        = decode_state(state);
  assign logic_sw_n = ctl.logic_sw_n;
  assign aux_en     = ctl.aux_en;
  assign core_en    = ctl.core_en;
  assign main_en    = ctl.main_en;
  assign neg_en     = ctl.neg_en;
  assign pos_en     = ctl.pos_en;
  assign pos_dis    = ctl.pos_dis;
  assign fault      = ctl.fault;

endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic logic_sw_n,
  input logic core_en,
  input logic main_en,
  input logic neg_en,
  input logic pos_en,
  input logic fault
);

  // R2
  logic_before_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_sw_n) |-> !core_en);

  // R3
  main_after_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_en) |-> $past(core_en));

  // R4
  neg_needs_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_en |-> main_en);

  // R4
  pos_needs_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_en |-> neg_en);

  // R5
  gates_drop_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(neg_en) |-> !pos_en);

  // R6
  fault_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(main_en || neg_en || pos_en || core_en));

  // R7
  switch_release_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(logic_sw_n) && fault) |-> $past(fault));

endmodule

bind disp_pwr_seq disp_pwr_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .logic_sw_n (logic_sw_n),
  .core_en    (core_en),
  .main_en    (main_en),
  .neg_en     (neg_en),
  .pos_en     (pos_en),
  .fault      (fault)
);

// File: tb/tb_disp_pwr_seq.sv
`timescale 1ns/1ps
module tb_disp_pwr_seq;

  localparam int NFLT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, en = 0, vin_ok = 0, main_good = 0, neg_good = 0;
  logic main_flt = 0, neg_flt = 0, pos_flt = 0, neg_fb_dis = 0;
  logic main_low = 0, gate_hold = 0;
  logic logic_sw_n, aux_en, core_en, main_en, neg_en, pos_en, pos_dis, fault;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  disp_pwr_seq #(.FAULT_CYCLES(NFLT)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .en(en), .vin_ok(vin_ok),
    .main_good(main_good), .neg_good(neg_good), .main_flt(main_flt),
    .neg_flt(neg_flt), .pos_flt(pos_flt), .neg_fb_dis(neg_fb_dis),
    .main_low(main_low), .gate_hold(gate_hold),
    .logic_sw_n(logic_sw_n), .aux_en(aux_en), .core_en(core_en),
    .main_en(main_en), .neg_en(neg_en), .pos_en(pos_en),
    .pos_dis(pos_dis), .fault(fault)
  );

  // Reference model: behavioural, two-deep input delay queue, integer states
  // 0 rest,1 switch,2 core,3 main,4 neg,5 pos,6 pd gates,7 pd main,8 fault,9 fault held
  int        mst;
  int        mcnt;
  logic [10:0] dq[$];

  function automatic logic [10:0] pack_inputs();
    return {gate_hold, main_low, neg_fb_dis, pos_flt, neg_flt, main_flt,
            neg_good, main_good, vin_ok, en, run};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; mcnt = 0;
      dq = '{11'd0, 11'd0};
    end else begin
      logic [10:0] s;
      bit r, e, v, mg, ng, fl, fd, ml, gh, exp_hit;
      int nx;
      s  = dq[0];
      r  = s[0]; e = s[1]; v = s[2]; mg = s[3]; ng = s[4];
      fl = s[5] | s[6] | s[7]; fd = s[8]; ml = s[9]; gh = s[10];
      exp_hit = 0;
      if (mst == 5 && fl) begin
        mcnt = mcnt + 1;
        if (mcnt >= NFLT) exp_hit = 1;
      end else begin
        mcnt = 0;
      end
      nx = mst;
      if (!v) nx = 0;
      else begin
        case (mst)
          0: if (r) nx = 1;
          1: nx = r ? 2 : 0;
          2: if (!r) nx = 0; else if (e) nx = 3;
          3: if (!r) nx = 0; else if (!e) nx = 2; else if (mg) nx = 4;
          4: if (!r && gh) nx = 0; else if (!r || !e) nx = 6; else if (ng) nx = 5;
          5: if (exp_hit) nx = 8; else if (!r && gh) nx = 0; else if (!r || !e) nx = 6;
          6: if (!r && gh) nx = 0; else if (fd) nx = 7;
          7: nx = r ? 2 : 0;
          8: if (!r && !e) nx = 0; else if (ml) nx = 9;
          9: if (!r && !e) nx = 0;
          default: nx = 0;
        endcase
      end
      if (nx != 5) mcnt = 0;
      mst = nx;
      void'(dq.pop_front());
      dq.push_back(pack_inputs());
    end
  end

  function automatic logic [7:0] model_out(int st);
    // order: sw_n, aux, core, main, neg, pos, dis, fault
    case (st)
      1: return 8'b0100_0000;
      2: return 8'b0110_0000;
      3: return 8'b0111_0000;
      4: return 8'b0111_1000;
      5: return 8'b0111_1100;
      6: return 8'b0111_0010;
      7: return 8'b0110_0010;
      8: return 8'b0100_0001;
      9: return 8'b1000_0001;
      default: return 8'b1000_0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp_v, input string what);
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] m;
    m = model_out(mst);
    chk("R2",  logic_sw_n, m[7], "model logic_sw_n");
    chk("R7",  aux_en,     m[6], "model aux_en");
    chk("R2",  core_en,    m[5], "model core_en");
    chk("R3",  main_en,    m[4], "model main_en");
    chk("R4",  neg_en,     m[3], "model neg_en");
    chk("R4",  pos_en,     m[2], "model pos_en");
    chk("R5",  pos_dis,    m[1], "model pos_dis");
    chk("R6",  fault,      m[0], "model fault");
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rest_state(input string tag);
    chk(tag, logic_sw_n, 1'b1, "logic_sw_n rest");
    chk(tag, aux_en,  1'b0, "aux_en rest");
    chk(tag, core_en, 1'b0, "core_en rest");
    chk(tag, main_en, 1'b0, "main_en rest");
    chk(tag, neg_en,  1'b0, "neg_en rest");
    chk(tag, pos_en,  1'b0, "pos_en rest");
    chk(tag, pos_dis, 1'b0, "pos_dis rest");
    chk(tag, fault,   1'b0, "fault rest");
  endtask

  initial begin
    cyc(3);
    rest_state("R1");
    rst_n = 1'b1;
    cyc(2);
    rest_state("R1");

    // R11 / R2: three-edge latency, switch before core
    vin_ok = 1; run = 1;
    cyc(1); chk("R11", logic_sw_n, 1'b1, "one edge after run");
    cyc(1); chk("R11", logic_sw_n, 1'b1, "two edges after run");
    cyc(1); chk("R11", logic_sw_n, 1'b0, "three edges after run");
    chk("R2", core_en, 1'b0, "core waits one cycle");
    cyc(1); chk("R2", core_en, 1'b1, "core one cycle later");

    // R3: main only with en
    cyc(4); chk("R3", main_en, 1'b0, "main off while en low");
    en = 1; cyc(6);
    chk("R3", main_en, 1'b1, "main on with en");
    chk("R4", neg_en, 1'b0, "neg waits for main_good");
    main_good = 1; cyc(6);
    chk("R4", neg_en, 1'b1, "neg after main_good");
    chk("R4", pos_en, 1'b0, "pos waits for neg_good");
    neg_good = 1; cyc(6);
    chk("R4", pos_en, 1'b1, "pos after neg_good");

    // R6: short bursts do not trip the timer
    main_flt = 1; cyc(8); main_flt = 0; cyc(6);
    main_flt = 1; cyc(NFLT - 2); main_flt = 0; cyc(6);
    chk("R6", fault, 1'b0, "short bursts ignored");
    chk("R6", pos_en, 1'b1, "rails still on after bursts");
    pos_flt = 1; cyc(NFLT + 8);
    chk("R6", fault, 1'b1, "fault latched");
    chk("R6", main_en, 1'b0, "main off in fault");
    chk("R6", core_en, 1'b0, "core off in fault");
    chk("R7", logic_sw_n, 1'b0, "switch held before main_low");
    cyc(5);
    chk("R7", aux_en, 1'b1, "aux held before main_low");
    main_low = 1; cyc(5);
    chk("R7", logic_sw_n, 1'b1, "switch released after main_low");
    chk("R7", aux_en, 1'b0, "aux off after main_low");
    chk("R7", fault, 1'b1, "fault still set");
    pos_flt = 0; main_low = 0;

    // R8: one input low is not enough
    en = 0; cyc(6);
    chk("R8", fault, 1'b1, "en low alone keeps fault");
    en = 1; run = 0; cyc(6);
    chk("R8", fault, 1'b1, "run low alone keeps fault");
    en = 0; cyc(6);
    rest_state("R8");

    // R5: ordered power-down
    run = 1; en = 1; cyc(12);
    chk("R5", pos_en, 1'b1, "fully up before shutdown");
    run = 0; cyc(4);
    chk("R5", neg_en, 1'b0, "neg off on run low");
    chk("R5", pos_en, 1'b0, "pos off on run low");
    chk("R5", pos_dis, 1'b1, "discharge on");
    chk("R5", main_en, 1'b1, "main held until discharge crossing");
    neg_fb_dis = 1; cyc(3);
    chk("R5", main_en, 1'b0, "main off after crossing");
    chk("R5", logic_sw_n, 1'b0, "switch still on with main off");
    cyc(1);
    chk("R5", logic_sw_n, 1'b1, "switch off one cycle later");
    chk("R5", aux_en, 1'b0, "aux off one cycle later");
    neg_fb_dis = 0;

    // R10: external hold skips the ordered power-down
    run = 1; en = 1; cyc(12);
    gate_hold = 1; cyc(3);
    run = 0; cyc(4);
    rest_state("R10");
    gate_hold = 0;

    // R9: undervoltage from full-up and from fault
    run = 1; cyc(12);
    chk("R9", pos_en, 1'b1, "up before undervoltage");
    vin_ok = 0; cyc(4);
    rest_state("R9");
    vin_ok = 1; cyc(12);
    neg_flt = 1; cyc(NFLT + 8);
    chk("R6", fault, 1'b1, "fault from neg_flt");
    vin_ok = 0; cyc(4);
    rest_state("R9");
    neg_flt = 0;

    // R3: en drop before gate rails returns to core-only
    main_good = 0; vin_ok = 1; cyc(12);
    chk("R3", main_en, 1'b1, "main on, waiting for main_good");
    en = 0; cyc(4);
    chk("R3", main_en, 1'b0, "main off after en low");
    chk("R3", core_en, 1'b1, "core kept on");

    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule